// File: doc/BRIEF.md
# Message-Digest Engine Control and Input Front End

This block sits between a processor bus, a DMA channel and a message-digest core. Software programs one control register that holds the data ordering, the digest algorithm, plain or keyed (HMAC) operation, a long-key option, a DMA enable and a flag that marks a message spread over several DMA transfers. The algorithm, the keyed-mode flag and the long-key flag reach the core only when software writes the restart bit. A write without that bit changes the readable register and nothing else, so the configuration of a message cannot change while the message is being processed.

Each data word enters through one of two paths: a processor write to the data address, or a DMA acknowledge. The word is reordered according to the selected data type and placed in a one-word holding stage. The core reads it from that stage through a valid/take pair. A 4-bit count of accepted words and a holding-stage-full flag can be read back in the control register.

The DMA request follows a fixed set of rules. It stays up while a transfer is running, even if software clears the enable bit. It drops when the core is busy, when the stage is full and for one cycle after each acknowledge. On the last word the hardware clears the enable bit. Unless the multi-transfer flag is set, it also issues a digest-start pulse.

Top module: `hash_frontend`

## Requirements
- R1: After reset, `reg_rdata` reads 0, and `dma_req`, `core_valid`, `core_init` and `core_start` are low. `core_algo`, `core_hmac`, `core_longkey` and `exp_words` are 0.
- R2: The control register sits at `reg_addr`=0 and is read back on `reg_rdata`. The layout is: bit 0 restart (write-only, reads 0); bit 1 DMA enable; bits 3:2 data type; bit 4 keyed mode; bit 5 multi-transfer; bit 6 long key; bits 9:8 algorithm; bits 15:12 word count; bit 16 stage full. All other bits read 0. A control write with bit 0 set makes `core_init` high for the single following cycle. A write with bit 0 clear gives no pulse.
- R3: `core_algo`, `core_hmac` and `core_longkey` take new values only on a restart write, and they hold their values through all other writes. `core_longkey` is loaded with (bit 4 AND bit 6) of that write. The algorithm codes are 0 SHA-1, 1 MD5, 2 SHA-224 and 3 SHA-256.
- R4: A restart write sets `exp_words` to 17 (0x11).
- R5: The data type selects the reordering of each accepted word: 0 passes it unchanged; 1 swaps the two 16-bit halves; 2 reverses the four bytes; 3 reverses all 32 bits, so bit 0 goes to bit 31.
- R6: Each accepted word adds one to the 4-bit word count, which wraps from 15 to 0. A restart write clears the count.
- R7: An accepted word sets the stage-full flag (`core_valid`). `core_take` clears it. While the flag is set, a new word from the processor or the DMA is ignored and the held word stays unchanged. A processor data write is at `reg_addr`=1.
- R8: `dma_req` = (enable OR transfer running) AND NOT `core_busy` AND NOT full AND NOT (acknowledge in the previous cycle).
- R9: An accepted acknowledge with `dma_last` high clears the DMA enable bit, unless a control write in the same cycle sets that bit itself.
- R10: Clearing the enable bit after a non-final word does not stop the transfer: requests continue until the last word. A restart write ends the transfer. The enable bit always takes the value written, so a restart write does not clear it.
- R11: With the multi-transfer flag at 0, an accepted last word makes `core_start` high for one cycle. With the flag at 1, no pulse is given.
- R12: A restart write takes priority over a data word in the same cycle: that word is dropped and not counted. If the processor and the DMA deliver a word in the same cycle, the DMA word wins.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 1 | 0 = control register, 1 = data input |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Control register readback |
| dma_req | output | 1 | DMA request |
| dma_ack | input | 1 | DMA acknowledge, one word per cycle high |
| dma_data | input | 32 | DMA word, valid with dma_ack |
| dma_last | input | 1 | Marks the final word of the transfer |
| core_busy | input | 1 | Core cannot accept data |
| core_take | input | 1 | Core consumes the held word |
| core_valid | output | 1 | Held word present |
| core_data | output | 32 | Reordered held word |
| core_init | output | 1 | One-cycle core restart pulse |
| core_start | output | 1 | One-cycle digest-start pulse |
| core_algo | output | 2 | Latched algorithm |
| core_hmac | output | 1 | Latched keyed mode |
| core_longkey | output | 1 | Latched long-key flag |
| exp_words | output | 5 | Expected-word status value |

## Verification
A stale configuration latch shows up on `core_algo`, `core_hmac` or `core_longkey` one cycle after the faulty write. A lost transfer-running state shows up within a cycle or two, when a DMA request is missing or unexpected. A wrong full flag or word count changes `reg_rdata` and `core_valid` in the cycle after the word is accepted or taken. A wrong reordering appears on `core_data` in the same cycle that `core_valid` rises. The bench compares every output against a behavioural model on every cycle, so each of these faults is reported at the first cycle where it is visible.

// File: rtl/hfe_pkg.sv
`timescale 1ns/1ps
// Package: shared encodings and control-register field positions for the
// message-digest front end. Assumes a 32-bit control register.
package hfe_pkg;
    typedef enum logic [1:0] {DT_WORD = 2'd0, DT_HALF = 2'd1, DT_BYTE = 2'd2, DT_BIT = 2'd3} dtype_e;
    typedef enum logic [1:0] {AL_SHA1 = 2'd0, AL_MD5 = 2'd1, AL_SHA224 = 2'd2, AL_SHA256 = 2'd3} algo_e;

    typedef struct packed {
        algo_e algo;
        logic  hmac;
        logic  longkey;
    } core_cfg_t;

    localparam int F_RESTART = 0;
    localparam int F_DMAEN   = 1;
    localparam int F_DTYPE   = 2;
    localparam int F_KEYED   = 4;
    localparam int F_MULTI   = 5;
    localparam int F_LONGKEY = 6;
    localparam int F_ALGO    = 8;
    localparam int F_COUNT   = 12;
    localparam int F_FULL    = 16;
endpackage

// File: rtl/hfe_swizzle.sv
`timescale 1ns/1ps
// Module: hfe_swizzle
// Reorders one input word by data type: pass, half swap, byte reversal,
// full bit reversal. Purely combinational. Assumes DATA_W is a multiple of 16.
module hfe_swizzle #(
    parameter int DATA_W = 32
) (
    input  hfe_pkg::dtype_e     dtype,
    input  logic [DATA_W-1:0]   din,
    output logic [DATA_W-1:0]   dout
);
    localparam int NBYTE = DATA_W / 8;
    localparam int NHALF = DATA_W / 16;

    logic [DATA_W-1:0] by_bit, by_byte, by_half;

    for (genvar i = 0; i < DATA_W; i++) begin : g_bit
        assign by_bit[i] = din[DATA_W-1-i];
    end
    for (genvar j = 0; j < NBYTE; j++) begin : g_byte
        assign by_byte[j*8 +: 8] = din[(NBYTE-1-j)*8 +: 8];
    end
    for (genvar k = 0; k < NHALF; k++) begin : g_half
        assign by_half[k*16 +: 16] = din[(NHALF-1-k)*16 +: 16];
    end

    // Select the ordering for the configured data type.
    always_comb begin
        unique case (dtype)
            hfe_pkg::DT_HALF: dout = by_half;
            hfe_pkg::DT_BYTE: dout = by_byte;
            hfe_pkg::DT_BIT:  dout = by_bit;
            default:          dout = din;
        endcase
    end
endmodule

// File: rtl/hfe_din_stage.sv
`timescale 1ns/1ps
// Module: hfe_din_stage
// One-word holding stage towards the core, with a wrapping count of pushed
// words. Assumes the caller only pushes while the stage is empty.
module hfe_din_stage #(
    parameter int DATA_W = 32,
    parameter int CNT_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              push,
    input  logic [DATA_W-1:0] push_data,
    input  logic              take,
    output logic              full,
    output logic [DATA_W-1:0] held,
    output logic [CNT_W-1:0]  count
);
    // Holding register and full flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            full <= 1'b0;
            held <= '0;
        end else if (clear) begin
            full <= 1'b0;
        end else if (push) begin
            full <= 1'b1;
            held <= push_data;
        end else if (take) begin
            full <= 1'b0;
        end
    end

    // Word count, wraps naturally at 2**CNT_W.
    always_ff @(posedge clk) begin
        if (!rst_n)     count <= '0;
        else if (clear) count <= '0;
        else if (push)  count <= count + 1'b1;
    end

    a_r7_push_empty: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> !full);
    a_r7_take_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (take && full && !clear) |=> !full);
    a_r6_count_step: assert property (@(posedge clk) disable iff (!rst_n)
        (push && !clear) |=> count == $past(count) + 1'b1);
endmodule

// File: rtl/hfe_dma_if.sv
`timescale 1ns/1ps
// Module: hfe_dma_if
// DMA request generation, running-transfer tracking and the automatic
// digest-start pulse. Assumes ack_acc is qualified by the caller.
module hfe_dma_if (
    input  logic clk,
    input  logic rst_n,
    input  logic dma_en,
    input  logic restart,
    input  logic busy,
    input  logic full,
    input  logic multi,
    input  logic dma_ack,
    input  logic ack_acc,
    input  logic last,
    output logic dma_req,
    output logic core_start
);
    logic running, ack_d;

    // Transfer stays alive between first and last accepted word.
    always_ff @(posedge clk) begin
        if (!rst_n)       running <= 1'b0;
        else if (restart) running <= 1'b0;
        else if (ack_acc) running <= ~last;
    end

    // Acknowledge delay for the one-cycle request gap, and start pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ack_d      <= 1'b0;
            core_start <= 1'b0;
        end else begin
            ack_d      <= dma_ack;
            core_start <= ack_acc & last & ~multi;
        end
    end

    assign dma_req = (dma_en | running) & ~busy & ~full & ~ack_d;

    a_r8_full_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        full |-> !dma_req);
    a_r8_ack_gap: assert property (@(posedge clk) disable iff (!rst_n)
        dma_ack |=> !dma_req);
    a_r11_start_src: assert property (@(posedge clk) disable iff (!rst_n)
        core_start |-> $past(ack_acc && last && !multi));
endmodule

// File: rtl/hfe_ctrl_regs.sv
`timescale 1ns/1ps
// Module: hfe_ctrl_regs
// Software-visible control fields and the core configuration latch that
// loads only on a restart write. Assumes one control write per cycle.
module hfe_ctrl_regs #(
    parameter int EXP_W     = 5,
    parameter int EXP_START = 17
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               ctrl_wr,
    input  logic [31:0]        wdata,
    input  logic               last_acc,
    output logic               dma_en,
    output hfe_pkg::dtype_e    dtype,
    output logic               keyed,
    output logic               multi,
    output logic               longkey,
    output hfe_pkg::algo_e     algo,
    output logic               core_init,
    output hfe_pkg::core_cfg_t cfg,
    output logic [EXP_W-1:0]   exp_words
);
    import hfe_pkg::*;
    logic restart;
    assign restart = ctrl_wr & wdata[F_RESTART];

    // Readable fields; hardware clears the DMA enable on the last word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dma_en  <= 1'b0;
            dtype   <= DT_WORD;
            keyed   <= 1'b0;
            multi   <= 1'b0;
            longkey <= 1'b0;
            algo    <= AL_SHA1;
        end else if (ctrl_wr) begin
            dma_en  <= wdata[F_DMAEN];
            dtype   <= dtype_e'(wdata[F_DTYPE +: 2]);
            keyed   <= wdata[F_KEYED];
            multi   <= wdata[F_MULTI];
            longkey <= wdata[F_LONGKEY];
            algo    <= algo_e'(wdata[F_ALGO +: 2]);
        end else if (last_acc) begin
            dma_en  <= 1'b0;
        end
    end

    // Core configuration, restart pulse and expected-word status.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            core_init <= 1'b0;
            cfg       <= '0;
            exp_words <= '0;
        end else begin
            core_init <= restart;
            if (restart) begin
                cfg.algo    <= algo_e'(wdata[F_ALGO +: 2]);
                cfg.hmac    <= wdata[F_KEYED];
                cfg.longkey <= wdata[F_KEYED] & wdata[F_LONGKEY];
                exp_words   <= EXP_W'(EXP_START);
            end
        end
    end

    a_r2_init_src: assert property (@(posedge clk) disable iff (!rst_n)
        core_init |-> $past(ctrl_wr && wdata[F_RESTART]));
    a_r3_cfg_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !core_init |-> $stable(cfg));
    a_r4_exp_set: assert property (@(posedge clk) disable iff (!rst_n)
        core_init |-> exp_words == EXP_W'(EXP_START));
    a_r9_autoclr: assert property (@(posedge clk) disable iff (!rst_n)
        (last_acc && !ctrl_wr) |=> !dma_en);
endmodule

// File: rtl/hash_frontend.sv
`timescale 1ns/1ps
// Module: hash_frontend
// Register and DMA front end of a message-digest core: control register,
// restart-gated configuration, data reordering and one-word input stage.
// Assumes a 32-bit bus; the DMA asserts dma_ack only in answer to dma_req.
module hash_frontend #(
    parameter int DATA_W    = 32,
    parameter int CNT_W     = 4,
    parameter int EXP_W     = 5,
    parameter int EXP_START = 17
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic              reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    output logic              dma_req,
    input  logic              dma_ack,
    input  logic [DATA_W-1:0] dma_data,
    input  logic              dma_last,
    input  logic              core_busy,
    input  logic              core_take,
    output logic              core_valid,
    output logic [DATA_W-1:0] core_data,
    output logic              core_init,
    output logic              core_start,
    output logic [1:0]        core_algo,
    output logic              core_hmac,
    output logic              core_longkey,
    output logic [EXP_W-1:0]  exp_words
);
    import hfe_pkg::*;

    logic               ctrl_wr, data_wr, restart, full;
    logic               dma_acc, cpu_acc, push, last_acc;
    logic               dma_en, keyed, multi, longkey;
    dtype_e             dtype;
    algo_e              algo;
    core_cfg_t          cfg;
    logic [DATA_W-1:0]  raw_word, swz_word;
    logic [CNT_W-1:0]   count;

    // Decode writes and qualify word acceptance (restart first, DMA over CPU).
    always_comb begin
        ctrl_wr  = reg_wr & ~reg_addr;
        data_wr  = reg_wr & reg_addr;
        restart  = ctrl_wr & reg_wdata[F_RESTART];
        dma_acc  = dma_ack & ~full & ~restart;
        cpu_acc  = data_wr & ~dma_ack & ~full & ~restart;
        push     = dma_acc | cpu_acc;
        last_acc = dma_acc & dma_last;
        raw_word = dma_ack ? dma_data : reg_wdata[DATA_W-1:0];
    end

    hfe_ctrl_regs #(.EXP_W(EXP_W), .EXP_START(EXP_START)) u_regs (
        .clk(clk), .rst_n(rst_n), .ctrl_wr(ctrl_wr), .wdata(reg_wdata),
        .last_acc(last_acc), .dma_en(dma_en), .dtype(dtype), .keyed(keyed),
        .multi(multi), .longkey(longkey), .algo(algo), .core_init(core_init),
        .cfg(cfg), .exp_words(exp_words)
    );

    hfe_swizzle #(.DATA_W(DATA_W)) u_swz (
        .dtype(dtype), .din(raw_word), .dout(swz_word)
    );

    hfe_din_stage #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_din (
        .clk(clk), .rst_n(rst_n), .clear(restart), .push(push),
        .push_data(swz_word), .take(core_take), .full(full),
        .held(core_data), .count(count)
    );

    hfe_dma_if u_dma (
        .clk(clk), .rst_n(rst_n), .dma_en(dma_en), .restart(restart),
        .busy(core_busy), .full(full), .multi(multi), .dma_ack(dma_ack),
        .ack_acc(dma_acc), .last(dma_last), .dma_req(dma_req),
        .core_start(core_start)
    );

    // Register readback and core configuration outputs.
    always_comb begin
        reg_rdata                  = '0;
        reg_rdata[F_DMAEN]         = dma_en;
        reg_rdata[F_DTYPE +: 2]    = dtype;
        reg_rdata[F_KEYED]         = keyed;
        reg_rdata[F_MULTI]         = multi;
        reg_rdata[F_LONGKEY]       = longkey;
        reg_rdata[F_ALGO +: 2]     = algo;
        reg_rdata[F_COUNT +: 4]    = 4'(count);
        reg_rdata[F_FULL]          = full;
        core_valid                 = full;
        core_algo                  = cfg.algo;
        core_hmac                  = cfg.hmac;
        core_longkey               = cfg.longkey;
    end

    a_r12_restart_drops: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> !core_valid && reg_rdata[F_COUNT +: 4] == 4'd0);
    a_r10_restart_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (restart && !reg_wdata[F_DMAEN]) |=> !dma_req);
endmodule

// File: tb/test_hash_frontend.sv
`timescale 1ns/1ps
// Bench: behavioural per-cycle model of the front end, compared on every
// falling edge; stimulus from tasks and small responder processes.
module test_hash_frontend;
    logic        clk = 1'b0, rst_n = 1'b0;
    logic        reg_wr = 1'b0, reg_addr = 1'b0;
    logic [31:0] reg_wdata = '0, reg_rdata;
    logic        dma_req, dma_ack = 1'b0, dma_last = 1'b0;
    logic [31:0] dma_data = '0;
    logic        core_busy = 1'b0, core_take = 1'b0;
    logic        core_valid, core_init, core_start, core_hmac, core_longkey;
    logic [31:0] core_data;
    logic [1:0]  core_algo;
    logic [4:0]  exp_words;

    int checks = 0, errors = 0, dma_left = 0, take_mode = 0, cyc = 0;
    bit started = 0, done = 0;

    always #10 clk = ~clk;

    hash_frontend i_hash_frontend (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .dma_req(dma_req),
        .dma_ack(dma_ack), .dma_data(dma_data), .dma_last(dma_last),
        .core_busy(core_busy), .core_take(core_take), .core_valid(core_valid),
        .core_data(core_data), .core_init(core_init), .core_start(core_start),
        .core_algo(core_algo), .core_hmac(core_hmac),
        .core_longkey(core_longkey), .exp_words(exp_words)
    );

    // ---------------- reference model ----------------
    bit       m_en, m_mode, m_multi, m_lk, m_full, m_hold, m_ackd, m_init, m_start;
    bit       c_hmac, c_lk;
    bit [1:0] m_dt, m_algo, c_algo;
    int       m_cnt, m_exp;
    bit [31:0] m_buf;

    function automatic bit [31:0] reorder(bit [31:0] x, bit [1:0] dt);
        bit [31:0] r;
        case (dt)
            2'd1: r = {x[15:0], x[31:16]};
            2'd2: r = {<<8{x}};
            2'd3: for (int i = 0; i < 32; i++) r[31-i] = x[i];
            default: r = x;
        endcase
        return r;
    endfunction

    always @(posedge clk) begin
        bit wc, wd, ini, adma, acpu;
        bit [1:0] dt_old;
        bit multi_old;
        started = 1;
        if (!rst_n) begin
            {m_en, m_mode, m_multi, m_lk, m_full, m_hold, m_ackd, m_init, m_start} = '0;
            {c_hmac, c_lk, m_dt, m_algo, c_algo} = '0;
            m_cnt = 0; m_exp = 0; m_buf = '0;
        end else begin
            wc = reg_wr && !reg_addr;
            wd = reg_wr && reg_addr;
            ini = wc && reg_wdata[0];
            adma = dma_ack && !m_full && !ini;
            acpu = wd && !dma_ack && !m_full && !ini;
            dt_old = m_dt; multi_old = m_multi;
            m_init = ini;
            m_start = adma && dma_last && !multi_old;
            if (adma && dma_last) m_en = 0;
            if (wc) begin
                m_en = reg_wdata[1]; m_dt = reg_wdata[3:2]; m_mode = reg_wdata[4];
                m_multi = reg_wdata[5]; m_lk = reg_wdata[6]; m_algo = reg_wdata[9:8];
            end
            if (ini) begin
                c_algo = reg_wdata[9:8]; c_hmac = reg_wdata[4];
                c_lk = reg_wdata[4] && reg_wdata[6];
                m_exp = 17; m_cnt = 0; m_full = 0; m_hold = 0;
            end else begin
                if (adma) m_hold = !dma_last;
                if (core_take && m_full) m_full = 0;
                else if (adma || acpu) begin
                    m_full = 1;
                    m_buf = reorder(adma ? dma_data : reg_wdata, dt_old);
                    m_cnt = (m_cnt + 1) % 16;
                end
            end
            m_ackd = dma_ack;
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h at cycle %0d", tag, act, exp, cyc);
        end
    endtask

    // Compare every output on the falling edge.
    always @(negedge clk) begin
        bit [31:0] exp_rd;
        cyc++;
        if (started) begin
            exp_rd = {15'b0, m_full, 4'(m_cnt), 2'b0, m_algo, 1'b0, m_lk, m_multi,
                      m_mode, m_dt, m_en, 1'b0};
            chk("R1 R2 R6 R9 R10 reg_rdata", reg_rdata, exp_rd);
            chk("R8 R10 dma_req", 32'(dma_req),
                32'((m_en || m_hold) && !core_busy && !m_full && !m_ackd));
            chk("R7 core_valid", 32'(core_valid), 32'(m_full));
            chk("R5 R12 core_data", core_data, m_buf);
            chk("R2 core_init", 32'(core_init), 32'(m_init));
            chk("R11 core_start", 32'(core_start), 32'(m_start));
            chk("R3 core_cfg", {28'b0, core_algo, core_hmac, core_longkey},
                {28'b0, c_algo, c_hmac, c_lk});
            chk("R4 exp_words", 32'(exp_words), 32'(m_exp));
        end
    end

    // ---------------- stimulus ----------------
    // DMA responder: answers a visible request with one word.
    always begin
        @(negedge clk); #4;
        if (dma_left > 0 && dma_req) begin
            dma_ack = 1; dma_last = (dma_left == 1);
            dma_data = 32'h0F1E_2D3C ^ (32'(dma_left) * 32'h0101_0111);
            dma_left--;
        end else begin
            dma_ack = 0; dma_last = 0;
        end
    end

    // Core consumer: 0 never takes, 1 always, 2 every other cycle.
    always begin
        @(negedge clk); #2;
        core_take = core_valid && (take_mode == 1 || (take_mode == 2 && cyc[0]));
    end

    function automatic logic [31:0] mk(bit ini, bit en, bit [1:0] dt, bit mode,
                                       bit multi, bit lk, bit [1:0] alg);
        return {22'b0, alg, 1'b0, lk, multi, mode, dt, en, ini};
    endfunction

    task automatic wr(input bit a, input logic [31:0] d);
        @(negedge clk); #2;
        reg_wr = 1; reg_addr = a; reg_wdata = d;
        @(negedge clk); #2;
        reg_wr = 0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wait_dma(input int lvl);
        while (dma_left > lvl) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1;
        idle(3);                                             // R1 reset state
        wr(0, mk(1, 0, 0, 1, 0, 1, 3));                      // R2 R3 R4 restart
        wr(0, mk(0, 0, 0, 0, 0, 0, 1));                      // R3 no effect on core
        wr(0, mk(1, 0, 0, 0, 0, 1, 2));                      // R3 long key gated
        idle(2);
        for (int d = 0; d < 4; d++) begin                    // R5 each ordering
            take_mode = 0;
            wr(0, mk(0, 0, 2'(d), 0, 0, 0, 2));
            wr(1, 32'h8123_4567 + 32'(d));
            wr(1, 32'hDEAD_BEEF);                            // R7 ignored while full
            take_mode = 1; idle(3);
        end
        for (int i = 0; i < 18; i++) wr(1, 32'h1000_0000 * 32'(i % 16) + 32'(i)); // R6 wrap
        wr(0, mk(1, 0, 0, 0, 0, 0, 0));                      // R6 count cleared
        take_mode = 2;
        wr(0, mk(1, 1, 1, 0, 0, 0, 3));                      // R8 R9 R11 single transfer
        dma_left = 5;
        while (dma_left > 0) begin
            @(negedge clk); #2; core_busy = (cyc % 5 == 0);
        end
        core_busy = 0; idle(6);
        wr(0, mk(0, 1, 2, 0, 1, 0, 3));                      // R11 multi: no start
        dma_left = 3; wait_dma(0); idle(6);
        wr(0, mk(0, 1, 3, 0, 0, 0, 3));                      // R10 clear enable mid-run
        dma_left = 4; wait_dma(2);
        wr(0, mk(0, 0, 3, 0, 0, 0, 3));
        wait_dma(0); idle(6);
        wr(0, mk(0, 1, 0, 0, 0, 0, 1));                      // R10 restart ends transfer
        dma_left = 6; wait_dma(4);
        wr(0, mk(1, 0, 0, 0, 0, 0, 1));
        dma_left = 0; idle(6);
        wr(0, mk(0, 1, 0, 0, 0, 0, 1));                      // R10 restart keeps enable
        dma_left = 6; wait_dma(4);
        wr(0, mk(1, 1, 0, 0, 0, 0, 1));
        idle(4);
        forever begin                                        // R12 restart meets ack
            @(negedge clk); #3;
            if (dma_req) break;
        end
        reg_wr = 1; reg_addr = 0; reg_wdata = mk(1, 1, 2, 1, 0, 1, 0);
        @(negedge clk); #2; reg_wr = 0;
        wait_dma(0); idle(4);
        wr(0, mk(0, 0, 0, 0, 0, 0, 0));
        idle(6);
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule